// File: doc/BRIEF.md
# General-Purpose Port with PWM Pin Override

This block is an 8-bit general-purpose I/O port. Only its four low bits are connected to physical pins. Each of those pins is shared with one PWM output channel. Software reaches two registers over a small register bus: a data latch and a direction register. The PWM generator sits outside the block. For each channel it supplies an enable and the level to drive.

While a channel is enabled, it owns its pin. The pad is driven and carries the PWM level, whatever the port registers hold. When the channel is disabled, the pin returns to port control. A direction bit of 1 drives the latched value out. A direction bit of 0 leaves the pad in high impedance, and reads return the pin level after it passes through a synchronizer.

The four upper bits have no pins, so they act only as storage. Their direction bits are plain storage. Their data bits read back as 0 while the direction bit is 0, and as the stored value while it is 1.

Top module: `gpio_alt_port`

## Requirements
- R1: While reset is asserted and after its release, the direction register and the data latch hold 0, every `pin_oe` bit is 0 and every `pin_out` bit is 0.
- R2: A clock edge with `bus_we`=1 stores `bus_wdata` into the data latch when `bus_sel`=0, or into the direction register when `bus_sel`=1. The other register does not change.
- R3: With `bus_sel`=1, `bus_rdata` returns all 8 stored direction bits, including bits 7..4 that have no pin.
- R4: For a pin i in 0..3 whose channel is disabled (`pwm_en[i]`=0), `pin_oe[i]` equals direction bit i (1 = output, 0 = high-impedance input) and `pin_out[i]` equals data latch bit i.
- R5: For a pin i whose channel is enabled (`pwm_en[i]`=1), `pin_oe[i]` is 1 and `pin_out[i]` equals `pwm_lvl[i]`, whatever the direction and data bits hold.
- R6: With `bus_sel`=0, bit i in 0..3 of `bus_rdata` returns `pin_in[i]` when direction bit i is 0. A change on `pin_in` first shows up after the second rising clock edge.
- R7: With `bus_sel`=0, bits 7..4 of `bus_rdata` whose direction bit is 0 read as 0.
- R8: With `bus_sel`=0, any bit of `bus_rdata` whose direction bit is 1 returns the data latch bit, for bits with or without a pin.
- R9: A data write while a channel is enabled updates the latch without reaching that pin. The latched value appears on the pin once the channel is disabled.
- R10: A cycle with `bus_we`=0 changes neither register, whatever `bus_wdata` and `bus_sel` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register select: 0 = data latch, 1 = direction |
| bus_we | input | 1 | Write strobe, takes effect at the same clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the selected register |
| pwm_en | input | 4 | Per-channel PWM enable, one bit per pin |
| pwm_lvl | input | 4 | Per-channel PWM output level |
| pin_in | input | 4 | Pin levels seen at the pads |
| pin_oe | output | 4 | Pad output enable, 1 = drive |
| pin_out | output | 4 | Pad output value |

## Verification
The assertions watch every cycle for the following:
- the priority of enabled channels over the pad enable and level;
- pad enables that follow the direction bits when channels are disabled;
- register updates that happen only on a write strobe to the selected register;
- data reads that show the latch for output bits and 0 for input bits without a pin.

Other behaviour needs the bench's scenarios:
- the two-edge synchronizer latency on pin reads;
- the mixed readback of a half-input, half-output port;
- a latch written while a channel held the pin and then revealed when the channel is released;
- the cleared state after a reset applied mid-run.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned PORT_W      = 8;
  localparam int unsigned PIN_W       = 4;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_DIR  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_rstsync.sv
module gpio_port_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_port_insync.sv
module gpio_port_insync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = async_in;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q
);
  logic         data_ce;
  logic         dir_ce;
  logic [W-1:0] data_d;
  logic [W-1:0] dir_d;

  always_comb begin
    data_ce = wr_en && (wr_sel == SEL_DATA);
    dir_ce  = wr_en && (wr_sel == SEL_DIR);
    data_d  = data_ce ? wr_data : data_q;
    dir_d   = dir_ce  ? wr_data : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
    end
  end
endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad (
  input  logic dir_bit,
  input  logic data_bit,
  input  logic alt_en,
  input  logic alt_lvl,
  output logic pad_oe,
  output logic pad_out
);
  always_comb begin
    if (alt_en) begin
      pad_oe  = 1'b1;
      pad_out = alt_lvl;
    end else begin
      pad_oe  = dir_bit;
      pad_out = data_bit;
    end
  end
endmodule

// File: rtl/gpio_alt_port.sv
module gpio_alt_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned PORT_W      = gpio_port_pkg::PORT_W,
  parameter int unsigned PIN_W       = gpio_port_pkg::PIN_W,
  parameter int unsigned SYNC_STAGES = gpio_port_pkg::SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0]  pwm_en,
  input  logic [PIN_W-1:0]  pwm_lvl,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_oe,
  output logic [PIN_W-1:0]  pin_out
);
  logic              rst_q_n;
  logic [PORT_W-1:0] data_q;
  logic [PORT_W-1:0] dir_q;
  logic [PIN_W-1:0]  pin_sync;
  logic [PORT_W-1:0] data_view;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(bus_sel);

  gpio_port_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_q_n(rst_q_n)
  );

  gpio_port_regs #(.W(PORT_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr_en  (bus_we),
    .wr_sel (sel),
    .wr_data(bus_wdata),
    .data_q (data_q),
    .dir_q  (dir_q)
  );

  gpio_port_insync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .async_in(pin_in),
    .sync_out(pin_sync)
  );

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    if (i < PIN_W) begin : g_pin
      always_comb data_view[i] = dir_q[i] ? data_q[i] : pin_sync[i];
      gpio_port_pad u_pad (
        .dir_bit (dir_q[i]),
        .data_bit(data_q[i]),
        .alt_en  (pwm_en[i]),
        .alt_lvl (pwm_lvl[i]),
        .pad_oe  (pin_oe[i]),
        .pad_out (pin_out[i])
      );
    end else begin : g_nopin
      always_comb data_view[i] = dir_q[i] & data_q[i];
    end
  end

  always_comb bus_rdata = (sel == SEL_DIR) ? dir_q : data_view;
endmodule

// File: rtl/gpio_alt_port_chk.sv
module gpio_alt_port_chk #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned PIN_W  = 4
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [PORT_W-1:0] bus_wdata,
  input logic [PORT_W-1:0] bus_rdata,
  input logic [PIN_W-1:0]  pwm_en,
  input logic [PIN_W-1:0]  pwm_lvl,
  input logic [PIN_W-1:0]  pin_oe,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PORT_W-1:0] data_q,
  input logic [PORT_W-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (!rst_q_n) begin
      AST_RESET_CLEAR: assert (dir_q == '0 && data_q == '0 && pin_oe == (pin_oe & pwm_en)); // R1
    end
  end

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_we && !bus_sel) |=> (data_q == $past(bus_wdata))); // R2
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_we && bus_sel) |=> (dir_q == $past(bus_wdata))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !bus_we |=> ($stable(data_q) && $stable(dir_q))); // R10
  AST_DIR_READ: assert property (@(posedge clk) disable iff (!rst_q_n)
    bus_sel |-> (bus_rdata == dir_q)); // R3
  AST_PORT_DRIVE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (((pin_oe ^ dir_q[PIN_W-1:0]) | (pin_out ^ data_q[PIN_W-1:0])) & ~pwm_en) == '0); // R4
  AST_PWM_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((pin_oe & pwm_en) == pwm_en) && (((pin_out ^ pwm_lvl) & pwm_en) == '0)); // R5
  AST_NOPIN_INPUT_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    !bus_sel |-> ((bus_rdata[PORT_W-1:PIN_W] & ~dir_q[PORT_W-1:PIN_W]) == '0)); // R7
  AST_OUTPUT_READS_LATCH: assert property (@(posedge clk) disable iff (!rst_q_n)
    !bus_sel |-> (((bus_rdata ^ data_q) & dir_q) == '0)); // R8
endmodule

bind gpio_alt_port gpio_alt_port_chk #(.PORT_W(PORT_W), .PIN_W(PIN_W)) u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pwm_en   (pwm_en),
  .pwm_lvl  (pwm_lvl),
  .pin_oe   (pin_oe),
  .pin_out  (pin_out),
  .data_q   (data_q),
  .dir_q    (dir_q)
);

// File: tb/gpio_alt_port_test.sv
module gpio_alt_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {sel, we, wdata, pwm_en, pwm_lvl, pin_in, exp_rdata, exp_oe, exp_out}
  localparam logic [37:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'hA5, 4'h0, 4'h0, 4'h0, 8'hA5, 4'h5, 4'h0}, // R2 R3 direction write
    {1'b0, 1'b1, 8'h3C, 4'h0, 4'h0, 4'hA, 8'h2E, 4'h5, 4'hC}, // R2 R6 R7 R8 mixed read
    {1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 4'h5, 8'h24, 4'h5, 4'hC}, // R6 R10 new pin levels
    {1'b0, 1'b0, 8'h00, 4'h9, 4'h1, 4'h0, 8'h24, 4'hD, 4'h5}, // R5 channels 3 and 0 own pins
    {1'b0, 1'b1, 8'hFF, 4'h9, 4'h1, 4'h0, 8'hA5, 4'hD, 4'h7}, // R9 write under override
    {1'b1, 1'b1, 8'h0F, 4'h0, 4'h0, 4'h0, 8'h0F, 4'hF, 4'hF}, // R9 latch revealed
    {1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 8'h0F, 4'hF, 4'hF}, // R7 R8 upper inputs read 0
    {1'b1, 1'b1, 8'hF0, 4'h0, 4'h0, 4'h0, 8'hF0, 4'h0, 4'hF}, // R4 pins high-Z
    {1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 4'h6, 8'hF6, 4'h0, 4'hF}, // R6 R8 pinless outputs
    {1'b1, 1'b0, 8'h00, 4'h0, 4'h0, 4'h6, 8'hF0, 4'h0, 4'hF}  // R10 strobe low ignored
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] pwm_en = '0;
  logic [3:0] pwm_lvl = '0;
  logic [3:0] pin_in = '0;
  logic [3:0] pin_oe;
  logic [3:0] pin_out;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_alt_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_en(pwm_en),
    .pwm_lvl(pwm_lvl), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    bus_sel = 1'b1;
    chk("R1 dir during reset", bus_rdata, 8'h00);
    chk("R1 oe during reset", {4'h0, pin_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 dir after release", bus_rdata, 8'h00);
    bus_sel = 1'b0;
    chk("R1 data after release", bus_rdata, 8'h00);
    chk("R1 out after release", {pin_oe, pin_out}, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      {bus_sel, bus_we, bus_wdata, pwm_en, pwm_lvl, pin_in} = VEC[v][37:16];
      @(negedge clk);
      bus_we = 1'b0;
      repeat (2) @(negedge clk);
      chk($sformatf("vec%0d rdata R2/R3/R6/R7/R8/R10", v), bus_rdata, VEC[v][15:8]);
      chk($sformatf("vec%0d oe R4/R5", v), {4'h0, pin_oe}, {4'h0, VEC[v][7:4]});
      chk($sformatf("vec%0d out R4/R5/R9", v), {4'h0, pin_out}, {4'h0, VEC[v][3:0]});
    end

    // R6 latency: direction is F0, so the low bits read the synchronized pins
    bus_sel = 1'b0;
    pin_in = 4'h9;
    @(negedge clk);
    chk("R6 one edge, old level", bus_rdata, 8'hF6);
    @(negedge clk);
    chk("R6 two edges, new level", bus_rdata, 8'hF9);

    // R5: an enabled channel drives even a pin whose direction bit is input
    pwm_en = 4'h2;
    pwm_lvl = 4'h0;
    #1;
    chk("R5 override of input pin", {pin_oe, pin_out}, 8'h2D);
    pwm_en = 4'h0;

    // R1: reset applied mid-run clears both registers
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_sel = 1'b1;
    chk("R1 dir after mid-run reset", bus_rdata, 8'h00);
    bus_sel = 1'b0;
    pin_in = 4'h0;
    repeat (2) @(negedge clk);
    chk("R1 data after mid-run reset", bus_rdata, 8'h00);
    chk("R1 pads after mid-run reset", {pin_oe, pin_out}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule